// File: doc/BRIEF.md
# Page-Bounded Stream Prefetcher

This block sits next to a second-level cache and watches the line addresses of the read lookups that reach it. It accepts lookups from every requester: data loads, stores, first-level prefetchers and instruction fetch are all treated the same way. It keeps a small table of streams, and each stream is tied to one 4 KiB page. When it sees two lookups to neighbouring lines in the same page, it confirms a stream in that direction, either ascending or descending. From then on it issues prefetch line addresses ahead of the demand.

Each lookup to a confirmed stream allows at most two more prefetches. A stream never runs more than a set number of lines ahead of its latest demand, and it never leaves its page. Prefetch requests leave through a valid/ready port. While the port is stalled, the pending request is held, so no line is dropped or sent twice. Addresses on both ports are line addresses (byte address shifted right by 6, since a line is 64 bytes). The low 6 bits of a line address give the line's offset in its page, and the bits above them give the page number.

Top module: `stream_prefetcher`

## Requirements
- R1: The first lookup to an untracked page only allocates an entry and issues nothing. A following lookup to the line directly above or below the last one in that page confirms a stream and releases two prefetches.
- R2: An ascending stream confirmed at offset o prefetches o+1 and then o+2. Each further lookup one line higher continues with the next higher lines, in strictly increasing order.
- R3: A descending stream works the same way with lines in strictly decreasing order (o-1, o-2, ...).
- R4: Every prefetch lies in the page of the lookup that trained it. An ascending stream ends after offset 63 and a descending stream ends after offset 0. A stream is never carried into a neighbouring page; that page must train its own stream.
- R5: Each lookup to a stream refills its allowance to at most 2 prefetches. Unused allowance does not accumulate.
- R6: No prefetch is more than 20 lines ahead of the latest demand offset of its stream.
- R7: While pf_valid is high and pf_ready is low, pf_valid stays high and pf_line stays the same. After the stall, lines continue in order with none lost and none repeated.
- R8: A one-line step against the direction of a confirmed stream retrains the entry at once. It then issues two lines in the new direction.
- R9: The table holds 8 streams with least-recently-used replacement. Every lookup to a tracked page, including a repeat of the same line, refreshes that page's entry. A new page evicts the least recently used entry.
- R10: A lookup in a tracked page more than one line away from the last one cancels the stream and issues nothing. A repeat of the last line changes no stream state and issues nothing.
- R11: No prefetch targets a line at or behind the latest demand. When demand has overtaken the prefetch pointer, prefetching resumes one line past the demand.
- R12: After reset pf_valid is low and the table is empty, so a lookup next to a stream trained before reset issues nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A monitored second-level lookup is present |
| req_line | input | LINE_W | Line address of the lookup (page in upper bits, offset in low 6 bits) |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_line | output | LINE_W | Line address of the offered prefetch |
| pf_ready | input | 1 | The prefetch request is accepted when high with pf_valid |

## Verification
The assertions take for granted that req_line is known whenever req_valid is high, and that pf_ready may change only between clock edges. Lookups may arrive while a prefetch is stalled. The bench drives every input one time step after the rising edge and samples outputs on the falling edge. It spaces its lookups so that each lookup's released prefetches drain before the next one arrives, except in the stall test. That test deliberately stacks lookups behind a held request so that demand overtakes the prefetch pointer.

// File: rtl/spf_pkg.sv
package spf_pkg;
  // log2 of lines per 4 KiB page with 64-byte lines
  parameter int PG_OFF_W = 6;

  typedef logic [PG_OFF_W:0] off_ext_t;  // offset with one guard bit for leaving the page

  typedef enum logic { DIR_UP = 1'b0, DIR_DN = 1'b1 } dir_e;

  // next offset along the stream direction
  function automatic off_ext_t step_off(dir_e d, off_ext_t o);
    return (d == DIR_DN) ? (o - off_ext_t'(1)) : (o + off_ext_t'(1));
  endfunction

  // how many lines the prefetch pointer is ahead of the last demand
  function automatic off_ext_t lead_of(dir_e d, off_ext_t last, off_ext_t nxt);
    return (d == DIR_DN) ? (last - nxt) : (nxt - last);
  endfunction
endpackage

// File: rtl/spf_entry.sv
module spf_entry
  import spf_pkg::*;
#(
  parameter int LINE_W    = 30,
  parameter int MAX_AHEAD = 20,
  parameter int BURST     = 2,
  localparam int TAG_W    = LINE_W - PG_OFF_W,
  localparam int BW       = $clog2(BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] req_line,
  input  logic              lookup_i,
  input  logic              alloc_i,
  input  logic              issue_i,
  output logic              match_o,
  output logic              elig_o,
  output logic [LINE_W-1:0] pf_line_o
);
  logic             vld_q, vld_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  off_ext_t         last_q, last_d;
  dir_e             dir_q, dir_d;
  logic             conf_q, conf_d;
  off_ext_t         nxt_q, nxt_d;
  logic [BW-1:0]    bud_q, bud_d;

  logic [TAG_W-1:0] req_page;
  off_ext_t         req_off;
  logic             up_step, dn_step, in_page, behind;

  assign req_page  = req_line[LINE_W-1:PG_OFF_W];
  assign req_off   = {1'b0, req_line[PG_OFF_W-1:0]};
  assign up_step   = (req_off == last_q + off_ext_t'(1));
  assign dn_step   = (req_off + off_ext_t'(1) == last_q);
  assign in_page   = !nxt_q[PG_OFF_W];
  assign match_o   = vld_q && (tag_q == req_page);
  assign elig_o    = vld_q && conf_q && (bud_q != '0) && in_page &&
                     (lead_of(dir_q, last_q, nxt_q) <= off_ext_t'(MAX_AHEAD));
  assign pf_line_o = {tag_q, nxt_q[PG_OFF_W-1:0]};

  always_comb begin
    vld_d = vld_q; tag_d = tag_q; last_d = last_q; dir_d = dir_q;
    conf_d = conf_q; nxt_d = nxt_q; bud_d = bud_q;
    if (issue_i) begin
      nxt_d = step_off(dir_q, nxt_q);
      bud_d = bud_q - BW'(1);
    end
    behind = !nxt_d[PG_OFF_W] &&
             ((dir_q == DIR_DN) ? (nxt_d >= req_off) : (nxt_d <= req_off));
    if (alloc_i) begin
      vld_d = 1'b1; tag_d = req_page; last_d = req_off; dir_d = DIR_UP;
      conf_d = 1'b0; nxt_d = '0; bud_d = '0;
    end else if (lookup_i) begin
      if (up_step || dn_step) begin
        if (conf_q && (dir_q == dir_e'(dn_step))) begin
          last_d = req_off;
          bud_d  = BW'(BURST);
          if (behind) nxt_d = step_off(dir_q, req_off);
        end else begin
          dir_d  = dir_e'(dn_step);
          conf_d = 1'b1;
          last_d = req_off;
          nxt_d  = step_off(dir_e'(dn_step), req_off);
          bud_d  = BW'(BURST);
        end
      end else if (req_off != last_q) begin
        last_d = req_off; conf_d = 1'b0; bud_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0; tag_q <= '0; last_q <= '0; dir_q <= DIR_UP;
      conf_q <= 1'b0; nxt_q <= '0; bud_q <= '0;
    end else begin
      vld_q <= vld_d; tag_q <= tag_d; last_q <= last_d; dir_q <= dir_d;
      conf_q <= conf_d; nxt_q <= nxt_d; bud_q <= bud_d;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_o && !issue_i && !lookup_i && !alloc_i) |=> (elig_o && $stable(pf_line_o)));

  // R5
  budget_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bud_q <= BW'(BURST));

  // R2 R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !lookup_i && !alloc_i) |=> (nxt_q == step_off($past(dir_q), $past(nxt_q))));
endmodule

// File: rtl/spf_lru.sv
module spf_lru #(
  parameter int N   = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_i,
  input  logic [IW-1:0] touch_idx_i,
  output logic [IW-1:0] victim_o
);
  logic [IW-1:0] age_q [N];
  logic [N-1:0]  oldest;

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < N; i++) begin
      oldest[i] = (age_q[i] == IW'(N - 1));
      if (oldest[i]) victim_o = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx_i) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + IW'(1);
      end
    end
  end

  // R9
  one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1);
endmodule

// File: rtl/spf_arbiter.sv
module spf_arbiter #(
  parameter int N   = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
    any_o = |req_i;
    if (any_o) gnt_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
  import spf_pkg::*;
#(
  parameter int LINE_W    = 30,
  parameter int ENTRIES   = 8,
  parameter int MAX_AHEAD = 20,
  parameter int BURST     = 2,
  localparam int IW       = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_line,
  output logic              pf_valid,
  output logic [LINE_W-1:0] pf_line,
  input  logic              pf_ready
);
  logic [ENTRIES-1:0] match_vec, elig_vec, gnt_vec, issue_vec, lookup_vec, alloc_vec;
  logic [LINE_W-1:0]  line_arr [ENTRIES];
  logic [IW-1:0]      hit_idx, victim_idx, gnt_idx, touch_idx;
  logic               hit;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) hit_idx = IW'(i);
    end
  end

  assign hit       = |match_vec;
  assign touch_idx = hit ? hit_idx : victim_idx;
  assign issue_vec = (pf_valid && pf_ready) ? gnt_vec : '0;
  assign pf_line   = line_arr[gnt_idx];

  spf_lru #(.N(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_i(req_valid),
    .touch_idx_i(touch_idx), .victim_o(victim_idx)
  );

  spf_arbiter #(.N(ENTRIES)) u_arb (
    .req_i(elig_vec), .gnt_o(gnt_vec), .idx_o(gnt_idx), .any_o(pf_valid)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign lookup_vec[g] = req_valid && match_vec[g];
    assign alloc_vec[g]  = req_valid && !hit && (victim_idx == IW'(g));
    spf_entry #(.LINE_W(LINE_W), .MAX_AHEAD(MAX_AHEAD), .BURST(BURST)) u_ent (
      .clk(clk), .rst_n(rst_n), .req_line(req_line),
      .lookup_i(lookup_vec[g]), .alloc_i(alloc_vec[g]), .issue_i(issue_vec[g]),
      .match_o(match_vec[g]), .elig_o(elig_vec[g]), .pf_line_o(line_arr[g])
    );
  end

  // R9
  unique_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R7
  one_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_vec));

  // R7
  stall_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready && !req_valid) |=> pf_valid);
endmodule

// File: tb/stream_prefetcher_bench.sv
module stream_prefetcher_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 30;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [LW-1:0] req_line;
  logic          pf_ready;
  logic          pf_valid;
  logic [LW-1:0] pf_line;

  int checks = 0;
  int fails = 0;
  int rec_n = 0;
  logic [LW-1:0] rec [0:511];

  always #(CLK_PERIOD / 2) clk = ~clk;

  stream_prefetcher u_stream_prefetcher (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
    .pf_valid(pf_valid), .pf_line(pf_line), .pf_ready(pf_ready)
  );

  // accepted prefetches, seen between edges
  always @(negedge clk) begin
    if (rst_n && pf_valid && pf_ready) begin
      if (rec_n < 512) rec[rec_n] = pf_line;
      rec_n++;
    end
  end

  // mixed-scenario vectors: lookup line, new prefetches, first and second new line
  localparam int NV = 18;
  localparam int unsigned TV_LINE [NV] = '{202, 203, 204, 203, 202, 212, 213, 213,
                                           511, 510, 448, 449, 579, 578, 577, 576, 575, 574};
  localparam int unsigned TV_N    [NV] = '{0, 2, 2, 2, 2, 0, 2, 0, 0, 2, 0, 2, 0, 2, 0, 0, 0, 2};
  localparam int unsigned TV_A    [NV] = '{0, 204, 206, 202, 200, 0, 214, 0,
                                           0, 509, 0, 450, 0, 577, 0, 0, 0, 573};
  localparam int unsigned TV_B    [NV] = '{0, 205, 207, 201, 199, 0, 215, 0,
                                           0, 508, 0, 451, 0, 576, 0, 0, 0, 572};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic demand(input logic [LW-1:0] ln);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_line  = ln;
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    rec_n = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; req_valid = 1'b0; req_line = '0; pf_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R12 nothing offered out of reset
    chk(pf_valid == 1'b0, "R12 reset valid", pf_valid, 0);

    // table walk: R1 R2 R3 R4 R8 R10
    for (int v = 0; v < NV; v++) begin
      base = rec_n;
      demand(LW'(TV_LINE[v]));
      chk(rec_n - base == int'(TV_N[v]), $sformatf("R1/R2/R3/R4/R8/R10 vector %0d count", v),
          rec_n - base, TV_N[v]);
      if (TV_N[v] == 2 && rec_n - base == 2) begin
        chk(rec[base] == LW'(TV_A[v]), $sformatf("R2/R3/R8 vector %0d first", v), rec[base], TV_A[v]);
        chk(rec[base+1] == LW'(TV_B[v]), $sformatf("R2/R3/R8 vector %0d second", v), rec[base+1], TV_B[v]);
      end
    end

    // long ascending walk in page 20: R5 allowance, R6 lead cap, R4 end of page
    for (int k = 0; k < 46; k++) begin
      int en, ef;
      base = rec_n;
      demand(LW'(20 * 64 + k));
      en = (k == 0) ? 0 : (k <= 19) ? 2 : (k <= 43) ? 1 : 0;
      ef = (k <= 19) ? (20 * 64 + 2 * k) : (20 * 64 + k + 20);
      chk(rec_n - base == en, $sformatf("R5/R6 walk step %0d count", k), rec_n - base, en);
      if (en > 0 && rec_n - base == en) begin
        chk(rec[base] == LW'(ef), $sformatf("R6 walk step %0d line", k), rec[base], ef);
        chk(int'(rec[rec_n-1]) - (20 * 64 + k) <= 20, $sformatf("R6 walk step %0d lead", k),
            int'(rec[rec_n-1]) - (20 * 64 + k), 20);
      end
    end
    chk(rec[rec_n-1] == LW'(20 * 64 + 63), "R4 walk last line", rec[rec_n-1], 20 * 64 + 63);

    // stall: R7 hold and R11 overtaken pointer
    pf_ready = 1'b0;
    base = rec_n;
    demand(LW'(30 * 64 + 10));
    demand(LW'(30 * 64 + 11));
    demand(LW'(30 * 64 + 12));
    @(negedge clk);
    chk(pf_valid == 1'b1, "R7 held valid", pf_valid, 1);
    chk(pf_line == LW'(30 * 64 + 13), "R11 held line", pf_line, 30 * 64 + 13);
    @(negedge clk);
    chk(pf_line == LW'(30 * 64 + 13), "R7 line stable", pf_line, 30 * 64 + 13);
    chk(rec_n == base, "R7 nothing taken", rec_n - base, 0);
    @(posedge clk); #1;
    pf_ready = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk(rec_n - base == 2, "R7 count after stall", rec_n - base, 2);
    chk(rec[base] == LW'(30 * 64 + 13), "R11 first after stall", rec[base], 30 * 64 + 13);
    chk(rec[base+1] == LW'(30 * 64 + 14), "R7 second after stall", rec[base+1], 30 * 64 + 14);

    // R12 reset clears the table
    do_reset();
    @(negedge clk);
    chk(pf_valid == 1'b0, "R12 valid after reset", pf_valid, 0);
    base = rec_n;
    demand(LW'(30 * 64 + 13));
    chk(rec_n - base == 0, "R12 table cleared", rec_n - base, 0);

    // R9 replacement: fill eight pages, refresh the first, add a ninth
    do_reset();
    for (int p = 40; p < 48; p++) demand(LW'(p * 64 + 5));
    demand(LW'(40 * 64 + 5));
    demand(LW'(48 * 64 + 5));
    base = rec_n;
    demand(LW'(40 * 64 + 6));
    chk(rec_n - base == 2, "R9 refreshed page kept", rec_n - base, 2);
    base = rec_n;
    demand(LW'(41 * 64 + 6));
    chk(rec_n - base == 0, "R9 oldest page evicted", rec_n - base, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule